// File: doc/BRIEF.md
# Link Reset Request Gate with SerDes Lane Isolation

This block stands between a reset request that arrives asynchronously from the link side and the chip's reset and clock controller. A software-owned enable decides whether such a request is forwarded as a one-cycle device reset pulse or silently masked. Each forwarded request also sets a sticky event flag. Software can read the flag and clear it by writing a one. Only power-on reset and full reset clear it otherwise, so the flag survives the warm reset that the request itself may cause.

The block also drives the reset enables of two SerDes lane groups: the link lane group and the SGMII lane group. Power-on reset always resets both groups. For warm and full resets, a per-group isolation bit decides whether the group's reset is asserted, so a group can be kept running across those resets. Software reaches the state through a single-cycle 32-bit register port with two addresses. The control pins and the register port are plain, with no handshake, because no data stream passes through the block.

Top module: `rstreq_gate`

## Requirements
- R1: After power-on reset, both registers read 0, `dev_rst_req` is 0 and both `lane_rst` bits are 0.
- R2: While the enable (address 0, bit 1) is 0, a request on `link_req` produces no `dev_rst_req` pulse and leaves the event flag at 0.
- R3: While the enable is 1, a rising edge on `link_req` produces exactly one `dev_rst_req` pulse, one clock wide. The pulse is high after the third rising clock edge that follows the input rise. A request held high does not repeat the pulse.
- R4: A forwarded request sets the event flag, which reads at address 0, bit 4, in the same cycle as the pulse.
- R5: Writing address 0 with bit 9 set clears the event flag. Writing with bit 9 clear leaves the flag unchanged. Bit 9 always reads 0.
- R6: If a clear write and a forwarded request's edge fall in the same cycle, the flag ends up set.
- R7: `full_rst` clears the event flag and wins over a same-cycle set. `warm_rst` leaves the flag, the enable and the isolation bits unchanged.
- R8: While `por_n` is low, both `lane_rst` bits are 1 whatever the isolation bits say. Power-on reset clears the enable and the isolation bits.
- R9: While `warm_rst` or `full_rst` is high (with `por_n` high), `lane_rst[g]` equals the inverse of isolation bit g. Bit 0 is the link lane group and bit 1 is the SGMII group, both held at address 1. `lane_rst` follows the reset inputs in the same cycle, with no register in the path.
- R10: At address 0 only bits 1 and 4 can read 1. At address 1 only bits 1:0 can read 1. Writes to all other bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| full_rst | input | 1 | Full chip reset in progress, active high |
| warm_rst | input | 1 | Warm (non-power-on) chip reset in progress, active high |
| link_req | input | 1 | Asynchronous reset request from the link side |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 1 | Register select: 0 control/status, 1 isolation |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register, combinational |
| dev_rst_req | output | 1 | One-cycle device reset request to the clock/PLL controller |
| lane_rst | output | 2 | Reset enable per SerDes lane group (bit 0 link, bit 1 SGMII) |

## Verification
On every cycle, the assertions check these rules: a pulse only ever follows an enabled request, each pulse is one cycle wide, the flag is set with the pulse, the flag holds unless it is cleared, full reset clears it, and each lane reset follows its isolation bit during power-on, warm and full resets. Only the bench's scenarios can show the synchroniser latency, the masking of a request in the bench's own timeline, a same-cycle set and clear, the register bit layout, and that power-on reset clears the settings that warm reset keeps. The bench sweeps all isolation codes against both non-power-on reset kinds, and both enable values against a request.

// File: rtl/rstreq_pkg.sv
package rstreq_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned EN_BIT   = 1;
  localparam int unsigned STAT_BIT = 4;
  localparam int unsigned CLR_BIT  = 9;
  localparam logic        CTRL_SEL = 1'b0;
  localparam logic        ISO_SEL  = 1'b1;
endpackage

// File: rtl/rstreq_sync_edge.sv
module rstreq_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  // sh[0..STAGES-1] form the synchroniser; sh[STAGES] holds the previous value
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh[0] <= 1'b0;
    else        sh[0] <= din;
  end

  for (genvar i = 1; i <= STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh[i] <= 1'b0;
      else        sh[i] <= sh[i-1];
    end
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/rstreq_ctrl.sv
module rstreq_ctrl (
  input  logic clk,
  input  logic por_n,
  input  logic full_rst,
  input  logic wr_en_field,
  input  logic en_wval,
  input  logic clr_wr,
  input  logic req_rise,
  output logic en,
  output logic stat,
  output logic req_pulse
);
  logic fire;
  assign fire = req_rise & en;

  // enable: power-on reset only
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)           en <= 1'b0;
    else if (wr_en_field) en <= en_wval;
  end

  // sticky flag: full reset first, then set, then clear (set wins over clear)
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)        stat <= 1'b0;
    else if (full_rst) stat <= 1'b0;
    else if (fire)     stat <= 1'b1;
    else if (clr_wr)   stat <= 1'b0;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) req_pulse <= 1'b0;
    else        req_pulse <= fire;
  end
endmodule

// File: rtl/rstreq_iso.sv
module rstreq_iso #(
  parameter int unsigned GROUPS = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              warm_rst,
  input  logic              full_rst,
  input  logic              wr_iso,
  input  logic [GROUPS-1:0] iso_wval,
  output logic [GROUPS-1:0] iso,
  output logic [GROUPS-1:0] lane_rst
);
  logic non_por;
  assign non_por = warm_rst | full_rst;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)      iso <= '0;
    else if (wr_iso) iso <= iso_wval;
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_lane
    assign lane_rst[g] = ~por_n | (non_por & ~iso[g]);
  end
endmodule

// File: rtl/rstreq_gate.sv
module rstreq_gate
  import rstreq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned GROUPS      = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              full_rst,
  input  logic              warm_rst,
  input  logic              link_req,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              dev_rst_req,
  output logic [GROUPS-1:0] lane_rst
);
  logic              req_rise;
  logic              en_q;
  logic              stat_q;
  logic              clr_wr;
  logic              ctrl_wr;
  logic              iso_wr;
  logic [GROUPS-1:0] iso_q;

  assign ctrl_wr = reg_wr & (reg_addr == CTRL_SEL);
  assign iso_wr  = reg_wr & (reg_addr == ISO_SEL);
  assign clr_wr  = ctrl_wr & reg_wdata[CLR_BIT];

  rstreq_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(por_n),
    .din  (link_req),
    .rise (req_rise)
  );

  rstreq_ctrl u_ctrl (
    .clk        (clk),
    .por_n      (por_n),
    .full_rst   (full_rst),
    .wr_en_field(ctrl_wr),
    .en_wval    (reg_wdata[EN_BIT]),
    .clr_wr     (clr_wr),
    .req_rise   (req_rise),
    .en         (en_q),
    .stat       (stat_q),
    .req_pulse  (dev_rst_req)
  );

  rstreq_iso #(.GROUPS(GROUPS)) u_iso (
    .clk     (clk),
    .por_n   (por_n),
    .warm_rst(warm_rst),
    .full_rst(full_rst),
    .wr_iso  (iso_wr),
    .iso_wval(reg_wdata[GROUPS-1:0]),
    .iso     (iso_q),
    .lane_rst(lane_rst)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == CTRL_SEL) begin
      reg_rdata[EN_BIT]   = en_q;
      reg_rdata[STAT_BIT] = stat_q;
    end else begin
      reg_rdata[GROUPS-1:0] = iso_q;
    end
  end
endmodule

// File: rtl/rstreq_gate_chk.sv
module rstreq_gate_chk #(
  parameter int unsigned GROUPS = 2
) (
  input logic              clk,
  input logic              por_n,
  input logic              full_rst,
  input logic              warm_rst,
  input logic              wr_clr,
  input logic              en,
  input logic              stat,
  input logic              dev_rst_req,
  input logic [GROUPS-1:0] iso,
  input logic [GROUPS-1:0] lane_rst
);
  AST_MASKED_NO_PULSE: assert property (@(posedge clk) disable iff (!por_n)
    dev_rst_req |-> $past(en)); // R2
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!por_n)
    dev_rst_req |=> !dev_rst_req); // R3
  AST_FLAG_WITH_PULSE: assert property (@(posedge clk) disable iff (!por_n)
    (dev_rst_req && !$past(full_rst)) |-> stat); // R4
  AST_CLEAR_UNLESS_SET: assert property (@(posedge clk) disable iff (!por_n)
    (wr_clr && !full_rst) |=> (!stat || dev_rst_req)); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    (stat && !full_rst && !wr_clr) |=> stat); // R7
  AST_FULL_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
    full_rst |=> !stat); // R7
  AST_POR_ALL_LANES: assert property (@(posedge clk)
    !por_n |-> (&lane_rst)); // R8
  for (genvar g = 0; g < GROUPS; g++) begin : g_iso
    AST_LANE_ISOLATION: assert property (@(posedge clk) disable iff (!por_n)
      (warm_rst || full_rst) |-> (lane_rst[g] == !iso[g])); // R9
  end
endmodule

bind rstreq_gate rstreq_gate_chk #(.GROUPS(GROUPS)) u_chk (
  .clk        (clk),
  .por_n      (por_n),
  .full_rst   (full_rst),
  .warm_rst   (warm_rst),
  .wr_clr     (clr_wr),
  .en         (en_q),
  .stat       (stat_q),
  .dev_rst_req(dev_rst_req),
  .iso        (iso_q),
  .lane_rst   (lane_rst)
);

// File: tb/sim_rstreq_gate.sv
`timescale 1ns/1ps
module sim_rstreq_gate;
  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        full_rst = 1'b0;
  logic        warm_rst = 1'b0;
  logic        link_req = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_addr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        dev_rst_req;
  logic [1:0]  lane_rst;

  int checks = 0;
  int fails = 0;
  int pulses = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rstreq_gate u0 (
    .clk(clk), .por_n(por_n), .full_rst(full_rst), .warm_rst(warm_rst),
    .link_req(link_req), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dev_rst_req(dev_rst_req), .lane_rst(lane_rst)
  );

  always @(negedge clk) if (por_n && dev_rst_req) pulses++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input string req, input logic a, input logic [31:0] exp);
    reg_addr = a;
    #0.5;
    chk(req, reg_rdata, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    // R8: power-on reset drives both lane resets
    repeat (3) @(negedge clk);
    chk("R8 por lanes", {30'd0, lane_rst}, 32'h3);
    por_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd("R1 ctrl", 1'b0, 32'h0);
    rd("R1 iso", 1'b1, 32'h0);
    chk("R1 pulse", {31'd0, dev_rst_req}, 32'h0);
    chk("R1 lanes", {30'd0, lane_rst}, 32'h0);

    // R10 bit layout (clear bit written too, flag is 0 anyway)
    wr(1'b0, 32'hFFFF_FFFF);
    rd("R10 ctrl bits", 1'b0, 32'h2);
    wr(1'b1, 32'hFFFF_FFFF);
    rd("R10 iso bits", 1'b1, 32'h3);
    wr(1'b1, 32'h0);
    rd("R10 iso cleared", 1'b1, 32'h0);

    // R2 / R3 sweep over enable values
    for (int e = 0; e < 2; e++) begin
      wr(1'b0, e[0] ? 32'h2 : 32'h0);
      pulses = 0;
      @(negedge clk); link_req = 1'b1;
      @(posedge clk); @(posedge clk); @(negedge clk);
      chk("R3 no early pulse", {31'd0, dev_rst_req}, 32'h0);
      @(negedge clk);
      chk(e[0] ? "R3 pulse" : "R2 masked pulse", {31'd0, dev_rst_req}, {31'd0, e[0]});
      rd(e[0] ? "R4 flag set" : "R2 flag untouched", 1'b0, e[0] ? 32'h12 : 32'h0);
      repeat (6) @(negedge clk);
      chk(e[0] ? "R3 one pulse" : "R2 no pulse", pulses, e);
      link_req = 1'b0;
      repeat (4) @(negedge clk);
    end

    // R5: write 0 to clear bit keeps flag, write 1 clears, clear reads 0
    wr(1'b0, 32'h2);
    rd("R5 zero write keeps", 1'b0, 32'h12);
    wr(1'b0, 32'h202);
    rd("R5 one write clears", 1'b0, 32'h2);

    // R6: clear and set in the same cycle
    @(negedge clk); link_req = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = 32'h202;
    @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
    chk("R6 pulse", {31'd0, dev_rst_req}, 32'h1);
    rd("R6 set wins", 1'b0, 32'h12);
    link_req = 1'b0;
    repeat (3) @(negedge clk);

    // R7: warm reset keeps flag, enable and isolation; full reset clears flag
    wr(1'b1, 32'h2);
    @(negedge clk); warm_rst = 1'b1;
    repeat (3) @(negedge clk); warm_rst = 1'b0;
    rd("R7 warm keeps flag", 1'b0, 32'h12);
    rd("R7 warm keeps iso", 1'b1, 32'h2);
    @(negedge clk); full_rst = 1'b1;
    @(negedge clk); full_rst = 1'b0;
    rd("R7 full clears flag", 1'b0, 32'h2);

    // R9: all isolation codes against both non-POR reset kinds
    for (int k = 0; k < 2; k++) begin
      for (int c = 0; c < 4; c++) begin
        wr(1'b1, c);
        @(negedge clk);
        if (k == 0) warm_rst = 1'b1; else full_rst = 1'b1;
        #0.5;
        chk("R9 lane isolation", {30'd0, lane_rst}, {30'd0, ~c[1:0]});
        @(negedge clk); warm_rst = 1'b0; full_rst = 1'b0;
        #0.5;
        chk("R9 lanes idle", {30'd0, lane_rst}, 32'h0);
      end
    end

    // R8: POR overrides isolation and clears settings
    wr(1'b1, 32'h3);
    @(negedge clk); por_n = 1'b0;
    #0.5;
    chk("R8 por overrides iso", {30'd0, lane_rst}, 32'h3);
    @(negedge clk); por_n = 1'b1;
    rd("R8 iso cleared by por", 1'b1, 32'h0);
    rd("R8 enable cleared by por", 1'b0, 32'h0);

    @(negedge clk);
    finish_run();
  end
endmodule